// File: doc/BRIEF.md
# Time-Slotted Mesh Router

This block is one node of a network-on-chip in which every link is shared by time division. It has five ports: one toward the local tile and one toward each of the four compass neighbours. Each port carries a single data word with a valid flag. Every output is one selector feeding one register, so a word moves exactly one hop per clock. No arbitration takes place. A slot counter steps through a fixed table that is compiled into the design. For the current slot, that table names which input each output takes, or marks the output as idle.

The schedule is a parameter. It is built off-line so that no two words ever need the same link in the same slot, which means the router needs neither storage nor backpressure. Because the table is constant logic, nothing has to be loaded at start-up. The router moves traffic from the first clock after reset. Routers in a mesh or torus share one reset, so their slot counters stay in step. A word that leaves a router in slot s is seen by its neighbour in slot s+1.

Top module: `tdm_router`

## Requirements
- R1: While reset is high, and on the first clock after it, every output valid is low and the slot counter holds 0.
- R2: The slot counter advances by one on every clock out of reset. After it reaches PERIOD-1 it returns to 0, and the table entry for slot 0 is then used again.
- R3: A table entry holds one 3-bit select per output. Entry s occupies SCHEDULE bits [s*15 +: 15], and the select for output o sits at bits [o*3 +: 3] of that entry. Outputs and inputs are numbered 0 local, 1 north, 2 south, 3 east and 4 west. Select codes 0 to 4 pick the input with that number, and codes 5, 6 and 7 mean idle.
- R4: A valid word present on the selected input while the counter shows slot s appears on that output after the next rising edge, exactly one cycle later, with its data unchanged.
- R5: An output whose select is idle in slot s shows valid low in the following cycle, whatever is on any input.
- R6: The valid flag travels with the data. If the selected input is not valid, the output shows valid low in the following cycle. Output data is meaningful only while its valid is high.
- R7: Several outputs may select the same input in one slot, and each of them then carries that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_loc_data | input | DATA_W | Word from the local tile |
| in_loc_valid | input | 1 | Local word is present |
| in_n_data | input | DATA_W | Word from the north neighbour |
| in_n_valid | input | 1 | North word is present |
| in_s_data | input | DATA_W | Word from the south neighbour |
| in_s_valid | input | 1 | South word is present |
| in_e_data | input | DATA_W | Word from the east neighbour |
| in_e_valid | input | 1 | East word is present |
| in_w_data | input | DATA_W | Word from the west neighbour |
| in_w_valid | input | 1 | West word is present |
| out_loc_data | output | DATA_W | Registered word to the local tile |
| out_loc_valid | output | 1 | Local output word is present |
| out_n_data | output | DATA_W | Registered word to the north |
| out_n_valid | output | 1 | North output word is present |
| out_s_data | output | DATA_W | Registered word to the south |
| out_s_valid | output | 1 | South output word is present |
| out_e_data | output | DATA_W | Registered word to the east |
| out_e_valid | output | 1 | East output word is present |
| out_w_data | output | DATA_W | Registered word to the west |
| out_w_valid | output | 1 | West output word is present |

## Verification
On every cycle, the assertions check the counter's step and wrap, the cleared outputs after reset, and the one-cycle relation between each output and the input its current select names, including idle slots. These checks rely on the select as the table delivers it. Only the bench's scenarios can show that the table is laid out and decoded as specified, because the bench computes each select from its own formula. The bench also covers the two-hop path through a chain of routers and the broadcast slot in which all outputs take the same input.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int NPORT      = 5;
  localparam int SEL_W      = 3;
  localparam int ENTRY_W    = NPORT * SEL_W;
  localparam int MAX_PERIOD = 16;

  localparam int P_LOC = 0;
  localparam int P_N   = 1;
  localparam int P_S   = 2;
  localparam int P_E   = 3;
  localparam int P_W   = 4;

  // Placeholder rotation table: output o takes input (s+o) mod 6, and 5 means idle.
  function automatic logic [MAX_PERIOD*ENTRY_W-1:0] build_default();
    logic [MAX_PERIOD*ENTRY_W-1:0] t;
    t = '0;
    for (int s = 0; s < MAX_PERIOD; s++)
      for (int o = 0; o < NPORT; o++)
        t[s*ENTRY_W + o*SEL_W +: SEL_W] = SEL_W'((s + o) % 6);
    return t;
  endfunction

  localparam logic [MAX_PERIOD*ENTRY_W-1:0] DEF_SCHED = build_default();
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int PERIOD = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst || slot == LAST) slot <= '0;
    else                     slot <= slot + 1'b1;
  end
endmodule

// File: rtl/tdm_sched_rom.sv
module tdm_sched_rom #(
  parameter int PERIOD  = 8,
  parameter int SLOT_W  = 3,
  parameter int NPORT   = 5,
  parameter int SEL_W   = 3,
  parameter logic [PERIOD*NPORT*SEL_W-1:0] SCHEDULE = '0
) (
  input  logic [SLOT_W-1:0]             slot,
  output logic [NPORT-1:0][SEL_W-1:0]   sel
);
  localparam int ENTRY_W = NPORT * SEL_W;

  logic [PERIOD-1:0][ENTRY_W-1:0] table_c;
  assign table_c = SCHEDULE;

  always_comb begin
    sel = table_c[slot];
  end
endmodule

// File: rtl/tdm_out_port.sv
module tdm_out_port #(
  parameter int DATA_W = 16,
  parameter int NPORT  = 5,
  parameter int SEL_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SEL_W-1:0]               sel,
  input  logic [NPORT-1:0][DATA_W-1:0]   in_data,
  input  logic [NPORT-1:0]               in_valid,
  output logic [DATA_W-1:0]              out_data,
  output logic                           out_valid
);
  localparam logic [SEL_W-1:0] NP = SEL_W'(NPORT);

  logic [DATA_W-1:0] nxt_data;
  logic              nxt_valid;

  always_comb begin
    nxt_data  = '0;
    nxt_valid = 1'b0;
    if (sel < NP) begin
      nxt_data  = in_data[sel];
      nxt_valid = in_valid[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_data  <= nxt_data;
      out_valid <= nxt_valid;
    end
  end
endmodule

// File: rtl/tdm_router.sv
module tdm_router #(
  parameter int DATA_W = 16,
  parameter int PERIOD = 8,
  parameter logic [PERIOD*tdm_pkg::ENTRY_W-1:0] SCHEDULE =
    tdm_pkg::DEF_SCHED[PERIOD*tdm_pkg::ENTRY_W-1:0]
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_loc_data,
  input  logic              in_loc_valid,
  input  logic [DATA_W-1:0] in_n_data,
  input  logic              in_n_valid,
  input  logic [DATA_W-1:0] in_s_data,
  input  logic              in_s_valid,
  input  logic [DATA_W-1:0] in_e_data,
  input  logic              in_e_valid,
  input  logic [DATA_W-1:0] in_w_data,
  input  logic              in_w_valid,
  output logic [DATA_W-1:0] out_loc_data,
  output logic              out_loc_valid,
  output logic [DATA_W-1:0] out_n_data,
  output logic              out_n_valid,
  output logic [DATA_W-1:0] out_s_data,
  output logic              out_s_valid,
  output logic [DATA_W-1:0] out_e_data,
  output logic              out_e_valid,
  output logic [DATA_W-1:0] out_w_data,
  output logic              out_w_valid
);
  import tdm_pkg::*;

  localparam int SLOT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [SLOT_W-1:0]                slot;
  logic [NPORT-1:0][SEL_W-1:0]      sel;
  logic [NPORT-1:0][DATA_W-1:0]     in_data;
  logic [NPORT-1:0]                 in_valid;
  logic [NPORT-1:0][DATA_W-1:0]     out_data;
  logic [NPORT-1:0]                 out_valid;

  assign in_data  = {in_w_data, in_e_data, in_s_data, in_n_data, in_loc_data};
  assign in_valid = {in_w_valid, in_e_valid, in_s_valid, in_n_valid, in_loc_valid};

  tdm_slot_counter #(.PERIOD(PERIOD), .SLOT_W(SLOT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .slot(slot)
  );

  tdm_sched_rom #(
    .PERIOD(PERIOD), .SLOT_W(SLOT_W), .NPORT(NPORT), .SEL_W(SEL_W), .SCHEDULE(SCHEDULE)
  ) u_rom (
    .slot(slot),
    .sel (sel)
  );

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    tdm_out_port #(.DATA_W(DATA_W), .NPORT(NPORT), .SEL_W(SEL_W)) u_port (
      .clk      (clk),
      .rst      (rst),
      .sel      (sel[o]),
      .in_data  (in_data),
      .in_valid (in_valid),
      .out_data (out_data[o]),
      .out_valid(out_valid[o])
    );
  end

  assign out_loc_data  = out_data[P_LOC];
  assign out_loc_valid = out_valid[P_LOC];
  assign out_n_data    = out_data[P_N];
  assign out_n_valid   = out_valid[P_N];
  assign out_s_data    = out_data[P_S];
  assign out_s_valid   = out_valid[P_S];
  assign out_e_data    = out_data[P_E];
  assign out_e_valid   = out_valid[P_E];
  assign out_w_data    = out_data[P_W];
  assign out_w_valid   = out_valid[P_W];
endmodule

// File: rtl/tdm_router_chk.sv
module tdm_router_chk #(
  parameter int DATA_W = 16,
  parameter int PERIOD = 8,
  parameter int SLOT_W = 3,
  parameter int NPORT  = 5,
  parameter int SEL_W  = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic [SLOT_W-1:0]            slot,
  input logic [NPORT-1:0][SEL_W-1:0]  sel,
  input logic [NPORT-1:0][DATA_W-1:0] in_data,
  input logic [NPORT-1:0]             in_valid,
  input logic [NPORT-1:0][DATA_W-1:0] out_data,
  input logic [NPORT-1:0]             out_valid
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PERIOD - 1);
  localparam logic [SEL_W-1:0]  NP   = SEL_W'(NPORT);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (slot == '0 && out_valid == '0));

  a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
    (slot != LAST) |=> (slot == $past(slot) + 1'b1));

  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    (slot == LAST) |=> (slot == '0));

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (sel[o] >= NP) |=> !out_valid[o]);

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
      (sel[o] < NP) |=> (out_valid[o] == $past(in_valid[sel[o]])));

    a_r4_word_hop: assert property (@(posedge clk) disable iff (rst)
      (sel[o] < NP && in_valid[sel[o]]) |=> (out_data[o] == $past(in_data[sel[o]])));
  end
endmodule

bind tdm_router tdm_router_chk #(
  .DATA_W(DATA_W), .PERIOD(PERIOD), .SLOT_W(SLOT_W),
  .NPORT(tdm_pkg::NPORT), .SEL_W(tdm_pkg::SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .slot(slot), .sel(sel),
  .in_data(in_data), .in_valid(in_valid),
  .out_data(out_data), .out_valid(out_valid)
);

// File: tb/sim_tdm_router.sv
`timescale 1ns/1ps
module sim_tdm_router;
  localparam int DW = 16;
  localparam int P  = 8;
  localparam int EW = 15;

  // Schedule of the first router: slot 3 sends north to every output (R7).
  function automatic int f0(int s, int o);
    if (s == 3) return 1;
    return (s + 2*o) % 8;
  endfunction
  function automatic int f1(int s, int o);
    return (s + 3*o + 1) % 7;
  endfunction
  function automatic logic [P*EW-1:0] mk0();
    logic [P*EW-1:0] v; v = '0;
    for (int s = 0; s < P; s++) for (int o = 0; o < 5; o++) v[s*EW + o*3 +: 3] = 3'(f0(s, o));
    return v;
  endfunction
  function automatic logic [P*EW-1:0] mk1();
    logic [P*EW-1:0] v; v = '0;
    for (int s = 0; s < P; s++) for (int o = 0; o < 5; o++) v[s*EW + o*3 +: 3] = 3'(f1(s, o));
    return v;
  endfunction
  localparam logic [P*EW-1:0] SCH0 = mk0();
  localparam logic [P*EW-1:0] SCH1 = mk1();

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [4:0][DW-1:0] in0_d, out0_d, in1_d, out1_d;
  logic [4:0]         in0_v, out0_v, in1_v, out1_v;

  tdm_router #(.DATA_W(DW), .PERIOD(P), .SCHEDULE(SCH0)) u0 (
    .clk(clk), .rst(rst),
    .in_loc_data(in0_d[0]), .in_loc_valid(in0_v[0]), .in_n_data(in0_d[1]), .in_n_valid(in0_v[1]),
    .in_s_data(in0_d[2]), .in_s_valid(in0_v[2]), .in_e_data(in0_d[3]), .in_e_valid(in0_v[3]),
    .in_w_data(in0_d[4]), .in_w_valid(in0_v[4]),
    .out_loc_data(out0_d[0]), .out_loc_valid(out0_v[0]), .out_n_data(out0_d[1]), .out_n_valid(out0_v[1]),
    .out_s_data(out0_d[2]), .out_s_valid(out0_v[2]), .out_e_data(out0_d[3]), .out_e_valid(out0_v[3]),
    .out_w_data(out0_d[4]), .out_w_valid(out0_v[4]));

  // Second router: its west input is the first router's east output.
  assign in1_d[4] = out0_d[3];
  assign in1_v[4] = out0_v[3];

  tdm_router #(.DATA_W(DW), .PERIOD(P), .SCHEDULE(SCH1)) u1 (
    .clk(clk), .rst(rst),
    .in_loc_data(in1_d[0]), .in_loc_valid(in1_v[0]), .in_n_data(in1_d[1]), .in_n_valid(in1_v[1]),
    .in_s_data(in1_d[2]), .in_s_valid(in1_v[2]), .in_e_data(in1_d[3]), .in_e_valid(in1_v[3]),
    .in_w_data(in1_d[4]), .in_w_valid(in1_v[4]),
    .out_loc_data(out1_d[0]), .out_loc_valid(out1_v[0]), .out_n_data(out1_d[1]), .out_n_valid(out1_v[1]),
    .out_s_data(out1_d[2]), .out_s_valid(out1_v[2]), .out_e_data(out1_d[3]), .out_e_valid(out1_v[3]),
    .out_w_data(out1_d[4]), .out_w_valid(out1_v[4]));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state held by the bench.
  logic [4:0][DW-1:0] p0_d, p1_d, e0_d, e1_d;
  logic [4:0]         p0_v, p1_v, e0_v, e1_v;
  int pslot;

  task automatic drive(int t);
    for (int p = 0; p < 5; p++) begin
      in0_d[p] = DW'(t*37 + p*1021 + 5);
      in0_v[p] = ((t + p) % 4) != 1;
    end
    for (int p = 0; p < 4; p++) begin
      in1_d[p] = DW'(t*91 + p*7 + 3);
      in1_v[p] = ((t*3 + p) % 5) != 0;
    end
  endtask

  task automatic cmp_port(string who, int o, int code, logic ev, logic [DW-1:0] ed,
                          logic av, logic [DW-1:0] ad);
    string req;
    // R3: codes 0..4 name an input, 5..7 are idle.
    if (code >= 5)            req = "R5";
    else if (!ev)             req = "R6";
    else if (pslot == 3)      req = "R7";
    else if (pslot == P - 1)  req = "R2";
    else                      req = "R4";
    n_cmp++;
    if (av !== ev || (ev && ad !== ed)) begin
      n_bad++;
      $display("FAIL %s %s out%0d slot%0d: valid=%0b data=%h expected valid=%0b data=%h",
               req, who, o, pslot, av, ad, ev, ed);
    end
  endtask

  task automatic step_model();
    logic [4:0][DW-1:0] w_d;
    logic [4:0]         w_v;
    w_d = p1_d; w_v = p1_v;
    w_d[4] = e0_d[3]; w_v[4] = e0_v[3];   // previous east output of the first router
    for (int o = 0; o < 5; o++) begin
      int c0, c1;
      c0 = f0(pslot, o);
      c1 = f1(pslot, o);
      e0_v[o] = (c0 < 5) ? p0_v[c0] : 1'b0;
      e0_d[o] = (c0 < 5) ? p0_d[c0] : '0;
      e1_v[o] = (c1 < 5) ? w_v[c1] : 1'b0;
      e1_d[o] = (c1 < 5) ? w_d[c1] : '0;
    end
    for (int o = 0; o < 5; o++) begin
      cmp_port("u0", o, f0(pslot, o), e0_v[o], e0_d[o], out0_v[o], out0_d[o]);
      cmp_port("u1", o, f1(pslot, o), e1_v[o], e1_d[o], out1_v[o], out1_d[o]);
    end
  endtask

  task automatic check_reset_outputs(string tag);
    n_cmp++;
    if (out0_v !== 5'b0 || out1_v !== 5'b0) begin
      n_bad++;
      $display("FAIL R1 %s: valids u0=%b u1=%b expected 00000", tag, out0_v, out1_v);
    end
  endtask

  task automatic run_cycles(int t0, int n);
    e0_v = '0; e0_d = '0; pslot = 0;
    drive(t0);
    p0_d = in0_d; p0_v = in0_v; p1_d = in1_d; p1_v = in1_v;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      step_model();
      pslot = (pslot + 1) % P;
      drive(t0 + k);
      p0_d = in0_d; p0_v = in0_v; p1_d = in1_d; p1_v = in1_v;
    end
  endtask

  initial begin
    in0_d = '0; in0_v = '1; in1_d[3:0] = '0; in1_v[3:0] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_outputs("power-up");           // R1
    rst = 1'b0;
    run_cycles(0, 6*P + 3);                     // several wraps (R2), every slot and code (R3)
    // Reset in mid-period: counter must restart at slot 0 (R1, R2).
    rst = 1'b1;
    @(negedge clk);
    check_reset_outputs("mid-run");
    rst = 1'b0;
    run_cycles(500, 3*P);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule